// File: doc/BRIEF.md
# Crossing Permission Controller for a Highway / One-Way Road Junction

This block decides, every clock cycle, which approaches of a road junction may cross. A two-way highway runs north–south and a one-way road enters from the west and runs east. There are no turns. Each approach has a car-presence sensor. A sensor is high while a car waits or crosses and drops once that car has gone through. The controller drives one registered permission output per approach.

The two highway directions never conflict with each other, so they form one group. Within that group each direction follows its own sensor. The eastbound road conflicts with both highway directions. The controller therefore alternates between the highway group and the east group. There is always an all-low cycle between the two groups. A maximum-green limit and a least-recently-served tie-break keep every waiting car from starving.

Top module: `junction_ctrl`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any clock edge that samples `rst` high, all three permission outputs are low, whatever the sensors show.
- R2: `go_e` is never high in the same cycle as `go_n` or `go_s`.
- R3: While the highway group holds the junction, `go_n` and `go_s` are registered copies of their own sensors (`car_n`, `car_s`). This means both may be high together, or either one alone.
- R4: When permission passes from one group to the other, at least one cycle with all outputs low lies between the last permission of one group and the first permission of the other.
- R5: A permission output is high only if its sensor was high at the previous clock edge. If a sensor is sampled low, its output is low in the next cycle.
- R6: A group keeps the junction while any of its sensors is high, unless the other group is waiting. When the other group is waiting, the holding group is released after at most `MAX_GREEN` cycles of permission, counted from its grant.
- R7: When both groups request while the junction is idle, the group served less recently wins. After reset the east group counts as less recently served, so it wins the first tie.
- R8: From the idle state, a lone requesting group is granted at the very next clock edge. Its outputs are high in the following cycle.
- R9: No sensor stays high with its permission low for more than `MAX_GREEN + 3` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_n | input | 1 | Northbound car present |
| car_s | input | 1 | Southbound car present |
| car_e | input | 1 | Eastbound car present |
| go_n | output | 1 | Northbound may cross |
| go_s | output | 1 | Southbound may cross |
| go_e | output | 1 | Eastbound may cross |

## Verification
The bench aims at four switch points:
- **East arriving mid-hold.** A north car sits in the highway group for a long time while an east car arrives. A design with a broken hold timer would then starve the east car forever, or cut the highway short.
- **Simultaneous requests from idle.** Both groups arrive together right after reset and again later. A tie-break that forgets its history would serve the same group twice and break the alternation.
- **Highway sensors overlapping.** The north and south sensors rise and fall at different times inside one hold. A design that treats the highway as one lamp would raise a direction with no car, or drop a direction that still has one.
- **Random traffic.** Long random stretches probe for a missing all-low cycle or a same-edge handover, which would show up as east and highway permission in adjacent cycles or in the same cycle.

// File: rtl/junction_pkg.sv
package junction_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_NS   = 2'd1,
    PH_E    = 2'd2
  } phase_t;

  typedef enum logic {
    GRP_NS = 1'b0,
    GRP_E  = 1'b1
  } grp_t;
endpackage

// File: rtl/junction_arbiter.sv
module junction_arbiter
  import junction_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pick_en,
  input  logic req_ns,
  input  logic req_e,
  output logic take_ns,
  output logic take_e
);
  grp_t last_q;

  // Tie goes to the group that was not served most recently.
  always_comb begin
    take_ns = 1'b0;
    take_e  = 1'b0;
    if (pick_en) begin
      if (req_ns && req_e) begin
        take_e  = (last_q == GRP_NS);
        take_ns = (last_q == GRP_E);
      end else begin
        take_ns = req_ns;
        take_e  = req_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          last_q <= GRP_NS;
    else if (take_ns) last_q <= GRP_NS;
    else if (take_e)  last_q <= GRP_E;
  end
endmodule

// File: rtl/junction_hold_timer.sv
module junction_hold_timer #(
  parameter int MAX_GREEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(MAX_GREEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_GREEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)     cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= LIMIT);
endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import junction_pkg::*;
#(
  parameter int MAX_GREEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic car_n,
  input  logic car_s,
  input  logic car_e,
  output logic go_n,
  output logic go_s,
  output logic go_e
);
  phase_t phase_q, phase_d;
  logic   req_ns;
  logic   take_ns, take_e;
  logic   expired;
  logic   in_idle;

  assign req_ns  = car_n | car_s;
  assign in_idle = (phase_q == PH_IDLE);

  junction_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .pick_en (in_idle),
    .req_ns  (req_ns),
    .req_e   (car_e),
    .take_ns (take_ns),
    .take_e  (take_e)
  );

  junction_hold_timer #(.MAX_GREEN(MAX_GREEN)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (in_idle),
    .expired (expired)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (take_ns)     phase_d = PH_NS;
        else if (take_e) phase_d = PH_E;
      end
      PH_NS: if (!req_ns || (expired && car_e)) phase_d = PH_IDLE;
      PH_E:  if (!car_e || (expired && req_ns)) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      go_n    <= 1'b0;
      go_s    <= 1'b0;
      go_e    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      go_n    <= (phase_d == PH_NS) && car_n;
      go_s    <= (phase_d == PH_NS) && car_s;
      go_e    <= (phase_d == PH_E)  && car_e;
    end
  end
endmodule

// File: rtl/junction_ctrl_chk.sv
module junction_ctrl_chk #(
  parameter int MAX_GREEN = 8
) (
  input logic clk,
  input logic rst,
  input logic car_n,
  input logic car_s,
  input logic car_e,
  input logic go_n,
  input logic go_s,
  input logic go_e
);
  localparam int BOUND = MAX_GREEN + 3;
  localparam int WW = $clog2(BOUND + 3);
  localparam logic [WW-1:0] SAT = {WW{1'b1}};

  logic [2:0]    car_v, go_v;
  logic [WW-1:0] wait_q [3];

  assign car_v = {car_e, car_s, car_n};
  assign go_v  = {go_e, go_s, go_n};

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rst || !car_v[i] || go_v[i]) wait_q[i] <= '0;
      else if (wait_q[i] != SAT)       wait_q[i] <= wait_q[i] + 1'b1;
    end
  end

  AST_E_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(go_e && (go_n || go_s))); // R2
  AST_GAP_AFTER_E: assert property (@(posedge clk) disable iff (rst)
    go_e |=> !(go_n || go_s)); // R4
  AST_GAP_AFTER_NS: assert property (@(posedge clk) disable iff (rst)
    (go_n || go_s) |=> !go_e); // R4
  AST_N_NEEDS_CAR: assert property (@(posedge clk) disable iff (rst)
    go_n |-> $past(car_n)); // R5
  AST_S_NEEDS_CAR: assert property (@(posedge clk) disable iff (rst)
    go_s |-> $past(car_s)); // R5
  AST_E_NEEDS_CAR: assert property (@(posedge clk) disable iff (rst)
    go_e |-> $past(car_e)); // R5
  AST_N_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (go_n && car_n && !car_e) |=> go_n); // R3
  AST_S_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (go_s && car_s && !car_e) |=> go_s); // R3
  AST_WAIT_N: assert property (@(posedge clk) disable iff (rst)
    32'(wait_q[0]) <= BOUND); // R9
  AST_WAIT_S: assert property (@(posedge clk) disable iff (rst)
    32'(wait_q[1]) <= BOUND); // R9
  AST_WAIT_E: assert property (@(posedge clk) disable iff (rst)
    32'(wait_q[2]) <= BOUND); // R9
endmodule

bind junction_ctrl junction_ctrl_chk #(.MAX_GREEN(MAX_GREEN)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .car_n (car_n),
  .car_s (car_s),
  .car_e (car_e),
  .go_n  (go_n),
  .go_s  (go_s),
  .go_e  (go_e)
);

// File: tb/tb_junction_ctrl.sv
`timescale 1ns/1ps
module tb_junction_ctrl;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_n = 1'b0, car_s = 1'b0, car_e = 1'b0;
  logic go_n, go_s, go_e;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  junction_ctrl #(.MAX_GREEN(G)) dut (
    .clk(clk), .rst(rst), .car_n(car_n), .car_s(car_s), .car_e(car_e),
    .go_n(go_n), .go_s(go_s), .go_e(go_e)
  );

  // Behavioural reference: who holds (0 none, 1 highway, 2 east),
  // green cycles elapsed, and who was served last (1 highway, 2 east).
  int  owner = 0;
  int  greens = 0;
  int  served_last = 1;
  bit  e_n = 0, e_s = 0, e_e = 0;

  always @(posedge clk) begin
    if (rst) begin
      owner = 0; greens = 0; served_last = 1;
    end else begin
      if (owner == 1) begin
        greens++;
        if (!(car_n || car_s) || (greens >= G && car_e)) owner = 0;
      end else if (owner == 2) begin
        greens++;
        if (!car_e || (greens >= G && (car_n || car_s))) owner = 0;
      end else begin
        if ((car_n || car_s) && car_e) owner = (served_last == 1) ? 2 : 1;
        else if (car_n || car_s)       owner = 1;
        else if (car_e)                owner = 2;
        if (owner != 0) begin served_last = owner; greens = 0; end
      end
    end
    e_n = !rst && owner == 1 && car_n;
    e_s = !rst && owner == 1 && car_s;
    e_e = !rst && owner == 2 && car_e;
  end

  // Compare every cycle at the falling edge, plus rule checks.
  bit prev_e = 0, prev_ns = 0;
  int wait_n = 0, wait_s = 0, wait_e = 0;
  always @(negedge clk) begin
    n_cmp++;
    if ({go_n, go_s, go_e} !== {e_n, e_s, e_e}) begin
      n_bad++;
      $display("FAIL %s: got n/s/e=%b%b%b expected %b%b%b at %0t",
               cur_req, go_n, go_s, go_e, e_n, e_s, e_e, $time);
    end
    n_cmp++;
    if (go_e && (go_n || go_s)) begin
      n_bad++;
      $display("FAIL R2: got e=%b ns=%b%b expected no overlap", go_e, go_n, go_s);
    end
    n_cmp++;
    if ((prev_e && (go_n || go_s)) || (prev_ns && go_e)) begin
      n_bad++;
      $display("FAIL R4: got handover without gap, expected all-low cycle");
    end
    prev_e = go_e; prev_ns = go_n || go_s;
    wait_n = (!rst && car_n && !go_n) ? wait_n + 1 : 0;
    wait_s = (!rst && car_s && !go_s) ? wait_s + 1 : 0;
    wait_e = (!rst && car_e && !go_e) ? wait_e + 1 : 0;
    n_cmp++;
    if (wait_n > G + 3 || wait_s > G + 3 || wait_e > G + 3) begin
      n_bad++;
      $display("FAIL R9: got waits %0d/%0d/%0d expected <= %0d",
               wait_n, wait_s, wait_e, G + 3);
    end
  end

  task automatic drive(input logic n, input logic s, input logic e, input int cyc);
    @(posedge clk); #1;
    car_n = n; car_s = s; car_e = e;
    repeat (cyc - 1) @(posedge clk);
  endtask

  initial begin
    // R1: reset with every sensor high
    cur_req = "R1";
    rst = 1'b1;
    drive(1, 1, 1, 3);
    @(posedge clk); #1; rst = 1'b0; car_n = 0; car_s = 0; car_e = 0;
    repeat (2) @(posedge clk);
    // R7: simultaneous requests after reset, east first
    cur_req = "R7";
    drive(1, 0, 1, 3 * G + 6);
    drive(0, 0, 0, 3);
    // R8: lone east request
    cur_req = "R8";
    drive(0, 0, 1, 4);
    drive(0, 0, 0, 3);
    // R3 / R5: overlapping highway sensors
    cur_req = "R3";
    drive(1, 0, 0, 2);
    drive(1, 1, 0, 2);
    cur_req = "R5";
    drive(0, 1, 0, 2);
    drive(0, 0, 0, 3);
    // R6: long north hold, east arrives mid-hold
    cur_req = "R6";
    drive(1, 0, 0, 3);
    drive(1, 0, 1, 2 * G + 8);
    drive(0, 0, 0, 3);
    // R1: reset in the middle of a hold
    cur_req = "R1";
    drive(0, 1, 0, 3);
    @(posedge clk); #1; rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    drive(0, 0, 0, 3);
    // R9: random traffic
    cur_req = "R9";
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 5) == 0) car_n = ~car_n;
      if ($urandom_range(0, 5) == 0) car_s = ~car_s;
      if ($urandom_range(0, 4) == 0) car_e = ~car_e;
    end
    drive(0, 0, 0, 4);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule